// File: doc/BRIEF.md
# Security Register Erase Engine

This block is the command engine of a serial flash that erases a bank of three 512-byte security registers, which sit apart from the main storage. A host drives it as an SPI slave in mode 0. Bits are sampled on rising SCLK while chip select is low, MSB first. The engine also samples the SPI pins with a faster system clock and finds the edges itself, so the whole block runs in one clock domain.

A frame is decoded when chip select rises. A write-enable frame arms the engine. A lock frame can set one-way lock bits on the registers. An erase frame names one register through address bits 15:12. The erase is self-timed: a counter keeps the busy flag high for a set number of clock cycles, then fills the selected register with 0xFF and drops the write-enable flag. A status-read frame shifts the status byte out on falling SCLK, so the host can poll for the end of the erase. The contents of the registers can be read through a plain side port, which the neighbouring read path uses.

Top module: `secreg_erase`

## Requirements
- R1: After reset, status_o is 0x00, so_o is 0 and every byte of all three registers reads 0x00.
- R2: A frame of exactly 8 bits carrying 0x06 sets the write-enable flag, status bit 1.
- R3: With write enable set, an erase frame starts a busy period. The frame is 0x44 followed by a 24-bit address, exactly 32 bits. Status bit 0 is then 1 for ERASE_CYCLES clock cycles, beginning one cycle after chip select rises. When it returns to 0, write enable clears in the same cycle, every byte of the selected register reads 0xFF, and the other registers are unchanged.
- R4: An erase frame sent while write enable is 0 has no effect.
- R5: Address bits 15:12 equal to 1, 2 or 3 select register 1, 2 or 3 (side-port index 0, 1, 2). Bits 8:0 are don't-care. If bits 23:16 are nonzero, if bits 11:9 are nonzero, or if any other select value is given, the erase is ignored and write enable is kept.
- R6: A frame whose bit count is not exactly the length of its command is discarded. This covers a chip select rise in mid-byte and extra bits.
- R7: With write enable set, a 16-bit frame of 0x01 and a data byte ORs data bits 5:3 into the lock bits and clears write enable. Lock bits show in status bits 5:3 (bit 3 is register 1) and are never cleared. Status bits 7:6 and 2 read 0.
- R8: An erase aimed at a locked register is ignored, and write enable is kept.
- R9: While status bit 0 is 1, write-enable, lock and erase frames are ignored.
- R10: After an 8-bit 0x05 opcode, so_o gives the status byte MSB first. It changes on each falling SCLK, starting at the falling edge that ends the opcode. The byte is taken again at the start of each byte period, and this works while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, samples the SPI pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | SPI chip select, active low |
| sclk_i | input | 1 | SPI serial clock |
| si_i | input | 1 | SPI data in |
| so_o | output | 1 | SPI data out (status read) |
| status_o | output | 8 | Status byte: busy bit 0, write enable bit 1, locks bits 5:3 |
| peek_reg_i | input | 2 | Side-port register index 0..2 |
| peek_off_i | input | 9 | Side-port byte offset |
| peek_data_o | output | 8 | Side-port byte read |

## Verification
The busy flag and the write-enable flag go to status_o straight from their registers. A wrong flag therefore shows in the cycle after the chip select rise that caused it. A timer that is off by any count shows as a busy period of the wrong length. A wrong target index, or a stray erase, shows as a whole register reading 0xFF or 0x00 on the side port as soon as the busy bit drops. If the bit counter or opcode capture is wrong, frames that should be discarded (short, long, locked, invalid address) change the status byte.

// File: rtl/secreg_pkg.sv
package secreg_pkg;
  localparam int N_SECREG = 3;
  localparam int SEL_W    = 2;
  localparam int CNT_W    = 6;

  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_LOCK  = 8'h01;
  localparam logic [7:0] OP_ERASE = 8'h44;
  localparam logic [7:0] OP_RDSR  = 8'h05;

  localparam logic [CNT_W-1:0] LEN_WREN  = 6'd8;
  localparam logic [CNT_W-1:0] LEN_LOCK  = 6'd16;
  localparam logic [CNT_W-1:0] LEN_ERASE = 6'd32;
endpackage

// File: rtl/secreg_spi_rx.sv
module secreg_spi_rx
  import secreg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sclk_i,
  input  logic             si_i,
  input  logic [7:0]       status_i,
  output logic             frame_end_o,
  output logic [CNT_W-1:0] bits_o,
  output logic [31:0]      sr_o,
  output logic             so_o
);
  logic             sclk_q, cs_q, in_read_q;
  logic [CNT_W-1:0] bits_q;
  logic [31:0]      sr_q;
  logic [2:0]       out_idx_q;
  logic [7:0]       snap_q;
  logic             rise, fall, cs_fall;

  assign rise        = sclk_i & ~sclk_q & ~cs_ni;
  assign fall        = ~sclk_i & sclk_q & ~cs_ni;
  assign cs_fall     = ~cs_ni & cs_q;
  assign frame_end_o = cs_ni & ~cs_q;
  assign bits_o      = bits_q;
  assign sr_o        = sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      cs_q   <= 1'b1;
      bits_q <= '0;
      sr_q   <= '0;
    end else begin
      sclk_q <= sclk_i;
      cs_q   <= cs_ni;
      if (cs_fall) begin
        bits_q <= '0;
        sr_q   <= '0;
      end else if (rise) begin
        sr_q <= {sr_q[30:0], si_i};
        if (bits_q != '1) bits_q <= bits_q + 1'b1;
      end
    end
  end

  // status shift-out, byte re-captured every 8 falling edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_read_q <= 1'b0;
      out_idx_q <= '0;
      snap_q    <= '0;
      so_o      <= 1'b0;
    end else if (cs_ni || cs_fall) begin
      in_read_q <= 1'b0;
      out_idx_q <= '0;
      so_o      <= 1'b0;
    end else begin
      if (bits_q == LEN_WREN && sr_q[7:0] == OP_RDSR) in_read_q <= 1'b1;
      if (fall && in_read_q) begin
        out_idx_q <= out_idx_q + 1'b1;
        if (out_idx_q == '0) begin
          snap_q <= status_i;
          so_o   <= status_i[7];
        end else begin
          so_o <= snap_q[3'd7 - out_idx_q];
        end
      end
    end
  end

  assert_read_after_opcode_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(in_read_q) |-> ($past(bits_q) == LEN_WREN && !cs_ni));
  assert_so_quiet_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cs_ni) |-> !so_o);
endmodule

// File: rtl/secreg_ctrl.sv
module secreg_ctrl
  import secreg_pkg::*;
#(
  parameter int ERASE_CYCLES = 256,
  localparam int TW = $clog2(ERASE_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_end_i,
  input  logic [CNT_W-1:0] bits_i,
  input  logic [31:0]      sr_i,
  output logic             erase_o,
  output logic [SEL_W-1:0] erase_sel_o,
  output logic [7:0]       status_o
);
  logic                wel_q, wip_q;
  logic [N_SECREG-1:0] lb_q;
  logic [TW-1:0]       timer_q;
  logic [SEL_W-1:0]    tgt_q, sel_idx;
  logic [3:0]          sel;
  logic                addr_ok, lock_hit, idle_end;
  logic                do_wren, do_lock, start_erase, done;

  always_comb begin
    sel      = sr_i[15:12];
    sel_idx  = SEL_W'(sel - 4'd1);
    addr_ok  = (sr_i[23:16] == 8'h00) && (sr_i[11:9] == 3'b000) &&
               (sel >= 4'd1) && (sel <= 4'(N_SECREG));
    lock_hit = |(lb_q & (N_SECREG'(1) << sel_idx));
    idle_end = frame_end_i && !wip_q;
    do_wren  = idle_end && bits_i == LEN_WREN && sr_i[7:0] == OP_WREN;
    do_lock  = idle_end && bits_i == LEN_LOCK && sr_i[15:8] == OP_LOCK && wel_q;
    start_erase = idle_end && bits_i == LEN_ERASE && sr_i[31:24] == OP_ERASE &&
                  wel_q && addr_ok && !lock_hit;
    done     = wip_q && timer_q == '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wel_q   <= 1'b0;
      wip_q   <= 1'b0;
      lb_q    <= '0;
      timer_q <= '0;
      tgt_q   <= '0;
    end else begin
      if (done) begin
        wip_q <= 1'b0;
        wel_q <= 1'b0;
      end else if (start_erase) begin
        wip_q   <= 1'b1;
        timer_q <= TW'(ERASE_CYCLES - 1);
        tgt_q   <= sel_idx;
      end else if (wip_q) begin
        timer_q <= timer_q - 1'b1;
      end
      if (do_wren) wel_q <= 1'b1;
      if (do_lock) begin
        lb_q  <= lb_q | sr_i[3 +: N_SECREG];
        wel_q <= 1'b0;
      end
    end
  end

  assign erase_o     = done;
  assign erase_sel_o = tgt_q;
  assign status_o    = {2'b00, lb_q, 1'b0, wel_q, wip_q};

  assert_busy_keeps_wel_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_q |-> wel_q);
  assert_timer_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wip_q |-> (timer_q < TW'(ERASE_CYCLES)));
  assert_start_needs_wel_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_q) |-> $past(wel_q));
  assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lb_q != '0) |=> ((lb_q & $past(lb_q)) == $past(lb_q)));
  assert_busy_freezes_lock_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wip_q) |-> $stable(lb_q));
endmodule

// File: rtl/secreg_array.sv
module secreg_array
  import secreg_pkg::*;
#(
  parameter int REG_BYTES = 512,
  localparam int OW = $clog2(REG_BYTES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             erase_i,
  input  logic [SEL_W-1:0] erase_sel_i,
  input  logic [SEL_W-1:0] rd_reg_i,
  input  logic [OW-1:0]    rd_off_i,
  output logic [7:0]       rd_data_o
);
  logic [N_SECREG-1:0][7:0] rd_byte;

  for (genvar r = 0; r < N_SECREG; r++) begin : g_reg
    logic [7:0] bytes_q [REG_BYTES];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int b = 0; b < REG_BYTES; b++) bytes_q[b] <= 8'h00;
      end else if (erase_i && erase_sel_i == SEL_W'(r)) begin
        for (int b = 0; b < REG_BYTES; b++) bytes_q[b] <= 8'hFF;
      end
    end
    assign rd_byte[r] = bytes_q[rd_off_i];
  end

  always_comb begin
    rd_data_o = 8'h00;
    for (int r = 0; r < N_SECREG; r++)
      if (rd_reg_i == SEL_W'(r)) rd_data_o = rd_byte[r];
  end

  assert_erase_target_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_i |-> (erase_sel_i < SEL_W'(N_SECREG)));
endmodule

// File: rtl/secreg_erase.sv
module secreg_erase
  import secreg_pkg::*;
#(
  parameter int ERASE_CYCLES = 256,
  parameter int REG_BYTES    = 512,
  localparam int OW = $clog2(REG_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_ni,
  input  logic          sclk_i,
  input  logic          si_i,
  output logic          so_o,
  output logic [7:0]    status_o,
  input  logic [1:0]    peek_reg_i,
  input  logic [OW-1:0] peek_off_i,
  output logic [7:0]    peek_data_o
);
  logic             frame_end, erase;
  logic [CNT_W-1:0] bits;
  logic [31:0]      sr;
  logic [SEL_W-1:0] erase_sel;
  logic [7:0]       status;

  secreg_spi_rx u_rx (
    .clk_i, .rst_ni, .cs_ni, .sclk_i, .si_i,
    .status_i    (status),
    .frame_end_o (frame_end),
    .bits_o      (bits),
    .sr_o        (sr),
    .so_o
  );

  secreg_ctrl #(.ERASE_CYCLES(ERASE_CYCLES)) u_ctrl (
    .clk_i, .rst_ni,
    .frame_end_i (frame_end),
    .bits_i      (bits),
    .sr_i        (sr),
    .erase_o     (erase),
    .erase_sel_o (erase_sel),
    .status_o    (status)
  );

  secreg_array #(.REG_BYTES(REG_BYTES)) u_array (
    .clk_i, .rst_ni,
    .erase_i     (erase),
    .erase_sel_i (erase_sel),
    .rd_reg_i    (peek_reg_i),
    .rd_off_i    (peek_off_i),
    .rd_data_o   (peek_data_o)
  );

  assign status_o = status;
endmodule

// File: tb/secreg_erase_bench.sv
module secreg_erase_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_BIT   = 4 * CLK_PERIOD;
  localparam int ERASE      = 1000;
  localparam int NVEC       = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, si = 1'b0;
  logic       so;
  logic [7:0] status, peek_data;
  logic [1:0] peek_reg = 2'd0;
  logic [8:0] peek_off = 9'd0;
  int         checks = 0, errors = 0, wip_cnt = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(negedge clk) if (status[0]) wip_cnt++;

  secreg_erase #(.ERASE_CYCLES(ERASE), .REG_BYTES(512)) u_secreg_erase (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .si_i(si),
    .so_o(so), .status_o(status),
    .peek_reg_i(peek_reg), .peek_off_i(peek_off), .peek_data_o(peek_data)
  );

  // {bit count, frame left-aligned in 40 bits, expected status, requirement}
  localparam logic [57:0] VECS [NVEC] = '{
    {6'd7,  40'h06_0000_0000, 8'h00, 4'd6},  // R6 short write enable
    {6'd9,  40'h06_0000_0000, 8'h00, 4'd6},  // R6 long write enable
    {6'd32, 40'h44_0010_0000, 8'h00, 4'd4},  // R4 erase without enable
    {6'd8,  40'h06_0000_0000, 8'h02, 4'd2},  // R2
    {6'd32, 40'h44_0110_0000, 8'h02, 4'd5},  // R5 bits 23:16 set
    {6'd32, 40'h44_0040_0000, 8'h02, 4'd5},  // R5 select 4
    {6'd32, 40'h44_0000_0000, 8'h02, 4'd5},  // R5 select 0
    {6'd32, 40'h44_0012_0000, 8'h02, 4'd5},  // R5 bit 9 set
    {6'd31, 40'h44_0010_0000, 8'h02, 4'd6},  // R6 mid-byte end
    {6'd33, 40'h44_0010_0000, 8'h02, 4'd6},  // R6 extra bit
    {6'd16, 40'h01_0800_0000, 8'h08, 4'd7},  // R7 lock register 1
    {6'd16, 40'h01_3800_0000, 8'h08, 4'd7},  // R7 lock without enable
    {6'd8,  40'h06_0000_0000, 8'h0A, 4'd2},  // R2
    {6'd32, 40'h44_0011_FF00, 8'h0A, 4'd8},  // R8 locked target
    {6'd16, 40'h01_0000_0000, 8'h08, 4'd7},  // R7 zeros do not clear
    {6'd8,  40'h06_0000_0000, 8'h0A, 4'd2}   // R2
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_frame(input int nbits, input logic [39:0] data);
    @(negedge clk);
    cs_n = 1'b0;
    #(HALF_BIT);
    for (int i = 0; i < nbits; i++) begin
      si = data[39 - i];
      #(HALF_BIT) sclk = 1'b1;
      #(HALF_BIT) sclk = 1'b0;
    end
    #(HALF_BIT) cs_n = 1'b1;
    #(HALF_BIT);
  endtask

  task automatic read_status(output logic [7:0] val);
    @(negedge clk);
    cs_n = 1'b0;
    #(HALF_BIT);
    for (int i = 0; i < 8; i++) begin
      si = 8'h05 >> (7 - i);
      #(HALF_BIT) sclk = 1'b1;
      #(HALF_BIT) sclk = 1'b0;
    end
    for (int i = 0; i < 8; i++) begin
      #(HALF_BIT) val[7 - i] = so;
      sclk = 1'b1;
      #(HALF_BIT) sclk = 1'b0;
    end
    #(HALF_BIT) cs_n = 1'b1;
    #(HALF_BIT);
  endtask

  task automatic region_all(input logic [1:0] r, input logic [7:0] exp, input string req);
    int bad = 0;
    logic [7:0] last = exp;
    peek_reg = r;
    for (int b = 0; b < 512; b++) begin
      peek_off = 9'(b);
      #1;
      if (peek_data !== exp) begin
        bad++;
        last = peek_data;
      end
    end
    chk(req, {24'd0, last}, {24'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 status", {24'd0, status}, 32'h0);
    chk("R1 so", {31'd0, so}, 32'h0);
    region_all(2'd0, 8'h00, "R1 reg1");
    region_all(2'd2, 8'h00, "R1 reg3");

    for (int v = 0; v < NVEC; v++) begin
      send_frame(int'(VECS[v][57:52]), VECS[v][51:12]);
      chk($sformatf("R%0d vec%0d", VECS[v][3:0], v), {24'd0, status}, {24'd0, VECS[v][11:4]});
    end
    region_all(2'd1, 8'h00, "R4 R5 no stray erase");

    read_status(rd);
    chk("R10 idle read", {24'd0, rd}, 32'h0A);

    // R3: erase register 2, address bits 8:0 all ones
    wip_cnt = 0;
    send_frame(32, 40'h44_0021_FF00);
    chk("R3 busy", {24'd0, status}, 32'h0B);
    send_frame(16, 40'h01_3800_0000);           // R9 lock while busy
    send_frame(32, 40'h44_0030_0000);           // R9 erase while busy
    read_status(rd);
    chk("R10 busy read", {24'd0, rd}, 32'h0B);
    chk("R9 lock frozen", {24'd0, status}, 32'h0B);
    while (status[0]) @(negedge clk);
    chk("R3 busy length", wip_cnt, ERASE);
    chk("R3 wel cleared", {24'd0, status}, 32'h08);
    region_all(2'd1, 8'hFF, "R3 target erased");
    region_all(2'd0, 8'h00, "R3 reg1 kept");
    region_all(2'd2, 8'h00, "R9 reg3 kept");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule